// File: doc/BRIEF.md
# Prescaled Multi-Timer Peripheral

This block is a bus-attached timer unit with four independent up-counters behind one APB3 slave port in a 4 KB window. One shared 16-bit prescaler divides the bus clock into a periodic tick. Each counter runs either on that tick or on every clock cycle. Timer 0 is 32 bits wide and timers 1 to 3 are 16 bits wide.

Each counter counts from zero up to its own programmable limit. When it reaches the limit it wraps to zero and keeps running. Each wrap latches a pending bit. The pending bits pass through a mask and are combined into one level-sensitive interrupt line for the processor.

Software programs the prescaler period and sets each timer's source, enable and limit. It can restart a counter at any time by writing its value register, and it acknowledges interrupts by writing ones to the pending register. Everything runs on the bus clock with an active-low synchronous reset.

Top module: `multi_timer_apb`

## Requirements
- R1: After reset every register reads zero, and `irq` is low.
- R2: Bits [15:0] at offset 0x00 hold the prescaler period P, and a read returns P. A write loads P and also restarts the prescaler's down-counter at P. The tick is high in each cycle where that counter is zero, and the counter then reloads P, so ticks recur every P+1 cycles.
- R3: Timer i (i = 0..3) has its control word at offset 0x10+0x10*i. Bit 0 enables the timer. Bit 1 set selects the prescaler tick as the count event, and bit 1 clear makes every clock cycle a count event. A disabled timer holds its value.
- R4: Timer i has its limit at offset 0x14+0x10*i. On a count event, a counter equal to its limit wraps to 0 and sets pending bit i. Otherwise the counter increments by one.
- R5: A read at offset 0x18+0x10*i returns timer i's counter. A write there with any data clears the counter to 0, and this takes precedence over a count event in the same cycle.
- R6: Timer 0 holds 32-bit limit and counter values. Timers 1 to 3 keep only bits [15:0] of their limit and counter.
- R7: The pending register at offset 0x80 has bit i for timer i in bits [3:0]. Writing 1 to a bit clears it. A wrap in the same cycle as the clear leaves the bit set.
- R8: The mask register at offset 0x84 uses bits [3:0]. `irq` is the OR of pending AND mask, and it goes high in the cycle after the clock edge that records the wrap.
- R9: A write takes effect when `psel`, `penable` and `pwrite` are all high. `pready` is always high and `pslverr` is always low. Reads of unmapped or unaligned addresses return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | Byte address within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Always zero |
| irq | output | 1 | Masked interrupt |

## Verification
The hardest case to reach is a wrap that lands in exactly the same cycle as a write-one-to-clear of the same pending bit, because the bus needs two cycles per transfer. The bench restarts a fast timer at a known cycle by writing its value register. It then issues the clear after a sweep of idle delays, so that one of the delays makes the clear's access phase coincide with the wrap. A behavioural model tracks the prescaler, the counters and the pending bits cycle by cycle. The bench compares `irq` against that model on every clock and compares each read against it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NUM_TMR  = 4;
    localparam int WIDE_W   = 32;
    localparam int NARROW_W = 16;
    localparam int PRE_W    = 16;
    localparam int ADDR_W   = 12;

    // word-index offsets (byte offset / 4)
    localparam logic [9:0] WIDX_PRESC = 10'h000;
    localparam logic [9:0] WIDX_PEND  = 10'h020;
    localparam logic [9:0] WIDX_MASK  = 10'h021;

    typedef enum logic [1:0] {
        RSEL_CTRL  = 2'd0,
        RSEL_LIMIT = 2'd1,
        RSEL_VALUE = 2'd2,
        RSEL_NONE  = 2'd3
    } tmr_rsel_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [PW-1:0] wdata,
    output logic [PW-1:0] period_o,
    output logic          tick_o
);
    typedef struct packed {
        logic [PW-1:0] period;
        logic [PW-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    assign tick_o   = (st_q.cnt == '0);
    assign period_o = st_q.period;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.period = wdata;
            st_d.cnt    = wdata;
        end else if (tick_o) begin
            st_d.cnt = st_q.period;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: after a tick the down-counter restarts at the period
    a_r2_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !wr) |=> (st_q.cnt == st_q.period));
    // R2: without a tick the counter steps down by one
    a_r2_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_o && !wr) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_ctrl,
    input  logic         wr_limit,
    input  logic         wr_value,
    input  logic [1:0]   wctrl,
    input  logic [W-1:0] wlimit,
    output logic [1:0]   ctrl_o,
    output logic [W-1:0] limit_o,
    output logic [W-1:0] value_o,
    output logic         wrap_o
);
    typedef struct packed {
        logic [1:0]   ctrl;
        logic [W-1:0] limit;
        logic [W-1:0] value;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    count_ev;

    assign count_ev = st_q.ctrl[0] && (st_q.ctrl[1] ? tick : 1'b1);
    assign wrap_o   = count_ev && (st_q.value == st_q.limit);
    assign ctrl_o   = st_q.ctrl;
    assign limit_o  = st_q.limit;
    assign value_o  = st_q.value;

    always_comb begin
        st_d = st_q;
        if (wr_ctrl)  st_d.ctrl  = wctrl;
        if (wr_limit) st_d.limit = wlimit;
        if (wr_value) begin
            st_d.value = '0;
        end else if (count_ev) begin
            st_d.value = wrap_o ? '0 : st_q.value + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: a wrap always leaves the counter at zero
    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (st_q.value == '0));
    // R3: a disabled timer with no restart keeps its value
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl[0] && !wr_value) |=> $stable(st_q.value));
    // R5: a restart write zeroes the counter
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wr_value |=> (st_q.value == '0));
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         wr_clr,
    input  logic         wr_mask,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] pend_o,
    output logic [N-1:0] mask_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [N-1:0] pend;
        logic [N-1:0] mask;
    } irq_st_t;

    irq_st_t      st_d, st_q;
    logic [N-1:0] clr_bits;

    assign clr_bits = wr_clr ? wdata : '0;

    always_comb begin
        st_d      = st_q;
        st_d.pend = set | (st_q.pend & ~clr_bits);
        if (wr_mask) st_d.mask = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign mask_o = st_q.mask;
    assign irq_o  = |(st_q.pend & st_q.mask);

    // R7: a wrap is always recorded, even against a clear
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((st_q.pend & $past(set)) == $past(set)));
    // R7: a clear without a coincident wrap drops the bit
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_bits & ~set)) |=> ((st_q.pend & $past(clr_bits & ~set)) == '0));
endmodule

// File: rtl/multi_timer_apb.sv
module multi_timer_apb
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              irq
);
    logic        wr_en, aligned;
    logic [9:0]  widx;
    tmr_rsel_e   rsel;
    logic [NUM_TMR-1:0] hit, wraps;
    logic [31:0] rd_ctrl  [NUM_TMR];
    logic [31:0] rd_limit [NUM_TMR];
    logic [31:0] rd_value [NUM_TMR];
    logic [PRE_W-1:0]   period;
    logic               tick;
    logic [NUM_TMR-1:0] pend, mask;

    assign wr_en   = psel && penable && pwrite;
    assign aligned = (paddr[1:0] == 2'b00);
    assign widx    = paddr[ADDR_W-1:2];
    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    always_comb begin
        case (paddr[3:2])
            2'd0:    rsel = RSEL_CTRL;
            2'd1:    rsel = RSEL_LIMIT;
            2'd2:    rsel = RSEL_VALUE;
            default: rsel = RSEL_NONE;
        endcase
    end

    tmr_prescaler #(.PW(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr_en && aligned && (widx == WIDX_PRESC)),
        .wdata    (pwdata[PRE_W-1:0]),
        .period_o (period),
        .tick_o   (tick)
    );

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        localparam int TW = (i == 0) ? WIDE_W : NARROW_W;
        logic [1:0]    c_q;
        logic [TW-1:0] l_q, v_q;

        assign hit[i] = aligned && (paddr[ADDR_W-1:4] == (ADDR_W-4)'(i + 1));

        tmr_counter #(.W(TW)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .wr_ctrl  (wr_en && hit[i] && (rsel == RSEL_CTRL)),
            .wr_limit (wr_en && hit[i] && (rsel == RSEL_LIMIT)),
            .wr_value (wr_en && hit[i] && (rsel == RSEL_VALUE)),
            .wctrl    (pwdata[1:0]),
            .wlimit   (pwdata[TW-1:0]),
            .ctrl_o   (c_q),
            .limit_o  (l_q),
            .value_o  (v_q),
            .wrap_o   (wraps[i])
        );

        assign rd_ctrl[i]  = 32'(c_q);
        assign rd_limit[i] = 32'(l_q);
        assign rd_value[i] = 32'(v_q);
    end

    tmr_irq_ctrl #(.N(NUM_TMR)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (wraps),
        .wr_clr  (wr_en && aligned && (widx == WIDX_PEND)),
        .wr_mask (wr_en && aligned && (widx == WIDX_MASK)),
        .wdata   (pwdata[NUM_TMR-1:0]),
        .pend_o  (pend),
        .mask_o  (mask),
        .irq_o   (irq)
    );

    always_comb begin
        prdata = '0;
        if (psel && aligned) begin
            if (widx == WIDX_PRESC) prdata = 32'(period);
            if (widx == WIDX_PEND)  prdata = 32'(pend);
            if (widx == WIDX_MASK)  prdata = 32'(mask);
            for (int i = 0; i < NUM_TMR; i++) begin
                if (hit[i]) begin
                    case (rsel)
                        RSEL_CTRL:  prdata = rd_ctrl[i];
                        RSEL_LIMIT: prdata = rd_limit[i];
                        RSEL_VALUE: prdata = rd_value[i];
                        default:    prdata = '0;
                    endcase
                end
            end
        end
    end

    // R8: interrupt line only with a pending, unmasked source
    a_r8_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|(pend & mask)));
endmodule

// File: tb/tb_multi_timer_apb.sv
module tb_multi_timer_apb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr, irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // behavioural model state
    bit [31:0] m_period, m_pcnt;
    bit [31:0] m_ctrl [4];
    bit [31:0] m_lim  [4];
    bit [31:0] m_val  [4];
    bit [3:0]  m_pend, m_mask;

    always #10 clk = ~clk;

    multi_timer_apb dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .irq(irq)
    );

    function automatic bit [31:0] wmask(int i);
        return (i == 0) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    endfunction

    function automatic bit [31:0] model_read(bit [11:0] a);
        if (a[1:0] != 2'b00) return 0;
        if (a == 12'h000) return m_period;
        if (a == 12'h080) return 32'(m_pend);
        if (a == 12'h084) return 32'(m_mask);
        for (int i = 0; i < 4; i++) begin
            if (a == 12'(16 * (i + 1)))     return m_ctrl[i];
            if (a == 12'(16 * (i + 1) + 4)) return m_lim[i];
            if (a == 12'(16 * (i + 1) + 8)) return m_val[i];
        end
        return 0;
    endfunction

    task automatic check(string req, bit [31:0] act, bit [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_period = 0; m_pcnt = 0; m_pend = 0; m_mask = 0;
        for (int i = 0; i < 4; i++) begin
            m_ctrl[i] = 0; m_lim[i] = 0; m_val[i] = 0;
        end
    endtask

    // one clock: advance the model with the inputs seen at the edge
    task automatic step();
        bit        wr, tick, ev;
        bit [3:0]  wraps;
        bit [31:0] nv [4];
        @(posedge clk);
        if (rst_n) begin
            wr    = psel && penable && pwrite;
            tick  = (m_pcnt == 0);
            wraps = 0;
            for (int i = 0; i < 4; i++) begin
                ev    = m_ctrl[i][0] && (m_ctrl[i][1] ? tick : 1'b1);
                nv[i] = m_val[i];
                if (ev) begin
                    if (m_val[i] == m_lim[i]) begin
                        nv[i] = 0; wraps[i] = 1;
                    end else nv[i] = (m_val[i] + 1) & wmask(i);
                end
                if (wr && paddr == 12'(16 * (i + 1) + 8)) nv[i] = 0;
            end
            if (wr && paddr == 12'h000) begin
                m_period = pwdata & 32'hFFFF; m_pcnt = m_period;
            end else if (tick) m_pcnt = m_period;
            else m_pcnt = m_pcnt - 1;
            m_pend = wraps | (m_pend & ~((wr && paddr == 12'h080) ? pwdata[3:0] : 4'h0));
            if (wr && paddr == 12'h084) m_mask = pwdata[3:0];
            for (int i = 0; i < 4; i++) begin
                m_val[i] = nv[i];
                if (wr && paddr == 12'(16 * (i + 1)))     m_ctrl[i] = pwdata & 32'h3;
                if (wr && paddr == 12'(16 * (i + 1) + 4)) m_lim[i]  = pwdata & wmask(i);
            end
        end
        @(negedge clk);
        check("R8 irq", 32'(irq), 32'(|(m_pend & m_mask)));
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic apb_write(bit [11:0] a, bit [31:0] d);
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        step();
        penable = 1;
        step();
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_read(bit [11:0] a, string req);
        psel = 1; penable = 0; pwrite = 0; paddr = a;
        step();
        penable = 1;
        #1;
        check(req, prdata, model_read(a));
        check("R9 pready/pslverr", {30'd0, pready, pslverr}, 32'h2);
        step();
        psel = 0; penable = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset values
        apb_read(12'h000, "R1 period");
        for (int i = 0; i < 4; i++) begin
            apb_read(12'(16 * (i + 1)), "R1 ctrl");
            apb_read(12'(16 * (i + 1) + 4), "R1 limit");
            apb_read(12'(16 * (i + 1) + 8), "R1 value");
        end
        apb_read(12'h080, "R1 pend");
        apb_read(12'h084, "R1 mask");

        // R6: width of limits
        apb_write(12'h014, 32'h0001_2345);
        apb_read(12'h014, "R6 wide limit");
        apb_write(12'h024, 32'h0001_2345);
        apb_read(12'h024, "R6 narrow limit");

        // R3/R4: timer0 on clock, limit 5, mask on
        apb_write(12'h084, 32'hF);
        apb_read(12'h084, "R8 mask");
        apb_write(12'h014, 32'd5);
        apb_write(12'h010, 32'h1);
        idle(4);
        apb_read(12'h018, "R4 value running");
        idle(9);
        apb_read(12'h080, "R4 pend set");
        // R7: clear pending
        apb_write(12'h080, 32'h1);
        apb_read(12'h080, "R7 pend after clear");
        // R8: masked pending keeps irq low
        apb_write(12'h084, 32'h0);
        idle(12);
        apb_read(12'h080, "R8 pend while masked");
        apb_write(12'h010, 32'h0);
        apb_write(12'h080, 32'hF);
        apb_write(12'h084, 32'hF);

        // R3: disabled timer holds
        apb_read(12'h018, "R3 held value a");
        idle(7);
        apb_read(12'h018, "R3 held value b");

        // R2: prescaler period 3, timer1 on tick, limit 2
        apb_write(12'h000, 32'h0001_0003);
        apb_read(12'h000, "R2 period");
        apb_write(12'h024, 32'd2);
        apb_write(12'h020, 32'h3);
        for (int k = 0; k < 6; k++) begin
            apb_read(12'h028, "R2 tick value");
            idle(k);
        end
        apb_read(12'h080, "R2 pend");

        // R5: value write clears
        apb_write(12'h028, 32'hFFFF);
        apb_read(12'h028, "R5 cleared");
        apb_write(12'h020, 32'h0);

        // R4: limit 0 wraps on each event (timer3, clock)
        apb_write(12'h080, 32'hF);
        apb_write(12'h044, 32'd0);
        apb_write(12'h040, 32'h1);
        idle(3);
        apb_read(12'h048, "R4 limit zero");
        apb_read(12'h080, "R4 pend limit zero");
        apb_write(12'h040, 32'h0);

        // R7: sweep clear against a coincident wrap (timer2, limit 3)
        apb_write(12'h034, 32'd3);
        apb_write(12'h030, 32'h1);
        for (int d = 0; d < 8; d++) begin
            apb_write(12'h038, 32'h0);
            idle(d);
            apb_write(12'h080, 32'h4);
            apb_read(12'h080, "R7 clear vs wrap");
        end
        apb_write(12'h030, 32'h0);

        // R9: unmapped and unaligned accesses
        apb_write(12'h0C0, 32'hFFFF_FFFF);
        apb_write(12'h015, 32'h7);
        apb_read(12'h0C0, "R9 unmapped read");
        apb_read(12'h015, "R9 unaligned read");
        apb_read(12'h014, "R9 limit untouched");
        apb_read(12'h01C, "R9 reserved slot");
        idle(20);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule